// File: doc/BRIEF.md
# Slave-Serial Bitstream Loader

This block loads a configuration bitstream into a downstream programmable device over a slave-serial link. A single start pulse drives the target's active-low program line low. The block waits until the target answers by pulling its active-low init line low, then releases the program line. It then waits out a settle delay and the recovery of init before it clocks out any data.

Bitstream bytes come in on a valid/ready byte stream, with a flag on the final byte. Each byte is sent most significant bit first, one bit for each serial clock period. Data changes only while the serial clock is low, and the target samples it on the rising edge.

After the final bit, the block holds the data line high and keeps the clock running while it watches the target. Done rising ends the run as a success. Init falling ends it as an error. Done not rising within a set number of trailing clocks ends it as a timeout. Init never answering the program pulse also ends it as a timeout. The init and done inputs pass through two-flop synchronizers before any logic uses them.

Top module: `bitload_ctrl`

## Requirements
- R1: While idle, a start pulse drives `cfg_prog_n` low in the next cycle, raises `busy` and clears all three result flags. A start pulse while `busy` is high has no effect on the program line or on the data sent.
- R2: `cfg_prog_n` stays low until the synchronized init line is seen low. It goes high on the third rising clock edge after `cfg_init_n` falls.
- R3: The first rising edge of `cfg_cclk` comes no sooner than WAIT_CYC + HALF_CYC cycles after `cfg_prog_n` rises. It also waits until init is high again.
- R4: Each byte is sent most significant bit first, one bit for each `cfg_cclk` period. `cfg_din` does not change while `cfg_cclk` is high.
- R5: While `busy` is high, every high phase of `cfg_cclk` lasts exactly HALF_CYC cycles and every low phase lasts at least HALF_CYC cycles.
- R6: A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while loading with no byte pending, and never while `busy` is low. Gaps in `in_valid` only stretch the low clock phase. `in_last` marks the final byte.
- R7: After the final bit, `cfg_din` is held at 1 while `cfg_cclk` keeps toggling. A rise of `cfg_done` sets `stat_ok` and drops `busy` on the third clock edge after it.
- R8: `cfg_init_n` falling while data or trailing clocks are being sent sets `stat_init_err` and drops `busy` on the third clock edge after it. After that, no further rising `cfg_cclk` edge occurs.
- R9: If done has not risen by the TRAIL_MAX-th trailing rising edge of `cfg_cclk`, `stat_timeout` is set on that same edge and the run ends.
- R10: If init never falls, `cfg_prog_n` stays low for exactly INIT_TMO cycles. `stat_timeout` is then set, the program line is released and no data is clocked.
- R11: After reset: `cfg_prog_n`=1, `cfg_cclk`=0, `cfg_din`=1, `busy`=0, `in_ready`=0 and all result flags are 0. At most one result flag is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a load |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of the bitstream |
| in_ready | output | 1 | Block takes the byte on this edge |
| cfg_prog_n | output | 1 | Active-low program request to the target |
| cfg_cclk | output | 1 | Serial configuration clock |
| cfg_din | output | 1 | Serial configuration data |
| cfg_init_n | input | 1 | Target's active-low init/error line (asynchronous) |
| cfg_done | input | 1 | Target's done line (asynchronous) |
| busy | output | 1 | A load is in progress |
| stat_ok | output | 1 | Last load ended with done high |
| stat_timeout | output | 1 | Last load ended in a timeout |
| stat_init_err | output | 1 | Last load ended with init low |

## Verification
Responses to the target's own lines each carry three register stages: two synchronizer flops and the sequencer. The bench therefore stamps the cycle in which it moves `cfg_init_n` or `cfg_done`, and expects the program-line release, the fall of `busy` and the matching flag exactly three cycles later. The program line is expected one cycle after start. Clock phases are counted on every cycle and compared with HALF_CYC at each edge. The init-timeout window is measured as the exact number of low program-line cycles. The trailing-clock timeout is checked by counting trailing rising edges up to the cycle in which the flag appears. All samples are taken on the falling system-clock edge, half a cycle after the registers update.

// File: rtl/bitload_pkg.sv
`timescale 1ns/1ps
// Shared types for the slave-serial bitstream loader.
package bitload_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,    // waiting for start
        PH_RESET,   // program line low, waiting for init low
        PH_SETTLE,  // program released, waiting out delay and init recovery
        PH_SHIFT,   // clocking bitstream bits
        PH_TRAIL    // trailing clocks, polling done/init
    } phase_e;
endpackage

// File: rtl/bitload_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer, one chain per bit.
// Assumes each input bit is a level that is independent of the others.
module bitload_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q;
        // Two-stage capture of the asynchronous level
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
            end else begin
                meta_q <= d[i];
                sync_q <= meta_q;
            end
        end
        assign q[i] = sync_q;
    end
endmodule

// File: rtl/bitload_shifter.sv
`timescale 1ns/1ps
// Byte intake, MSB-first serializer and serial clock generator.
// shift_en: take bytes and clock them out; trail_en: free-running clock with
// data high. With neither enabled the clock parks low and data parks high.
// Assumes HALF_CYC >= 1 and that shift_en and trail_en are never both high.
module bitload_shifter
    import bitload_pkg::*;
#(
    parameter int HALF_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              trail_en,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              cclk_o,
    output logic              din_o,
    output logic              stream_end,
    output logic              trail_rise
);
    localparam int HW   = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int BW   = $clog2(BYTE_W);
    localparam logic [HW-1:0] HC_TOP  = HW'(HALF_CYC - 1);
    localparam logic [BW-1:0] BIT_TOP = BW'(BYTE_W - 1);

    logic [BYTE_W-1:0] sh_q;
    logic [BW-1:0]     bit_q;
    logic [HW-1:0]     hc_q;
    logic              loaded_q, last_q, cclk_q;
    logic              tick;

    assign tick       = (hc_q == HC_TOP);
    assign in_ready   = shift_en && !loaded_q;
    assign stream_end = shift_en && loaded_q && tick && cclk_q && (bit_q == BIT_TOP) && last_q;
    assign trail_rise = trail_en && tick && !cclk_q;
    assign cclk_o     = cclk_q;
    assign din_o      = sh_q[BYTE_W-1];

    // Half-period counter: runs whenever the clock is toggling
    always_ff @(posedge clk) begin
        if (!rst_n)
            hc_q <= '0;
        else if (trail_en || (shift_en && loaded_q))
            hc_q <= tick ? '0 : hc_q + 1'b1;
        else
            hc_q <= '0;
    end

    // Serial clock and data: load, toggle, shift, park
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '1;
            bit_q    <= '0;
            loaded_q <= 1'b0;
            last_q   <= 1'b0;
            cclk_q   <= 1'b0;
        end else if (trail_en) begin
            sh_q     <= '1;
            loaded_q <= 1'b0;
            if (tick) cclk_q <= ~cclk_q;
        end else if (!shift_en) begin
            sh_q     <= '1;
            loaded_q <= 1'b0;
            cclk_q   <= 1'b0;
        end else if (!loaded_q) begin
            if (in_valid) begin
                sh_q     <= in_data;
                bit_q    <= '0;
                last_q   <= in_last;
                loaded_q <= 1'b1;
                cclk_q   <= 1'b0;
            end
        end else if (tick) begin
            if (!cclk_q) begin
                cclk_q <= 1'b1;
            end else begin
                cclk_q <= 1'b0;
                if (bit_q == BIT_TOP) begin
                    loaded_q <= 1'b0;
                end else begin
                    bit_q <= bit_q + 1'b1;
                    sh_q  <= {sh_q[BYTE_W-2:0], 1'b1};
                end
            end
        end
    end

    AST_DIN_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cclk_q && $past(cclk_q)) |-> $stable(sh_q[BYTE_W-1]))
        else $error("data moved while serial clock high"); // R4
    AST_TRAIL_DATA_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_en && $past(trail_en)) |-> din_o)
        else $error("data not high during trailing clocks"); // R7
    AST_BYTE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> loaded_q)
        else $error("accepted byte not held"); // R6
endmodule

// File: rtl/bitload_seq.sv
`timescale 1ns/1ps
// Load sequencer: program handshake, settle delay, loading, trailing-clock
// polling and result flags. init_hi/done_hi must already be synchronized.
// Assumes WAIT_CYC, TRAIL_MAX and INIT_TMO are all >= 1.
module bitload_seq
    import bitload_pkg::*;
#(
    parameter int WAIT_CYC  = 250,
    parameter int TRAIL_MAX = 64,
    parameter int INIT_TMO  = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic init_hi,
    input  logic done_hi,
    input  logic stream_end,
    input  logic trail_rise,
    output logic shift_en,
    output logic trail_en,
    output logic prog_n_o,
    output logic busy_o,
    output logic ok_o,
    output logic tmo_o,
    output logic err_o
);
    localparam int MAXV = (WAIT_CYC > INIT_TMO) ? ((WAIT_CYC > TRAIL_MAX) ? WAIT_CYC : TRAIL_MAX)
                                                : ((INIT_TMO > TRAIL_MAX) ? INIT_TMO : TRAIL_MAX);
    localparam int CW   = $clog2(MAXV + 1);

    phase_e        st;
    logic [CW-1:0] cnt;
    logic          prog_q, ok_q, tmo_q, err_q;

    assign shift_en = (st == PH_SHIFT);
    assign trail_en = (st == PH_TRAIL);
    assign busy_o   = (st != PH_IDLE);
    assign prog_n_o = prog_q;
    assign ok_o     = ok_q;
    assign tmo_o    = tmo_q;
    assign err_o    = err_q;

    // Phase sequencing, shared cycle/edge counter and program line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= PH_IDLE;
            cnt    <= '0;
            prog_q <= 1'b1;
        end else begin
            case (st)
                PH_IDLE: if (start) begin
                    st     <= PH_RESET;
                    cnt    <= '0;
                    prog_q <= 1'b0;
                end
                PH_RESET: if (!init_hi) begin
                    st     <= PH_SETTLE;
                    cnt    <= '0;
                    prog_q <= 1'b1;
                end else if (cnt == CW'(INIT_TMO - 1)) begin
                    st     <= PH_IDLE;
                    prog_q <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                PH_SETTLE: if (cnt == CW'(WAIT_CYC - 1)) begin
                    if (init_hi) begin
                        st  <= PH_SHIFT;
                        cnt <= '0;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
                PH_SHIFT: if (!init_hi) begin
                    st <= PH_IDLE;
                end else if (stream_end) begin
                    st  <= PH_TRAIL;
                    cnt <= '0;
                end
                PH_TRAIL: if (!init_hi || done_hi) begin
                    st <= PH_IDLE;
                end else if (trail_rise) begin
                    if (cnt == CW'(TRAIL_MAX - 1)) st <= PH_IDLE;
                    else                           cnt <= cnt + 1'b1;
                end
                default: st <= PH_IDLE;
            endcase
        end
    end

    // Result flags: cleared by an accepted start, set by the ending condition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q  <= 1'b0;
            tmo_q <= 1'b0;
            err_q <= 1'b0;
        end else if (st == PH_IDLE && start) begin
            ok_q  <= 1'b0;
            tmo_q <= 1'b0;
            err_q <= 1'b0;
        end else if (st == PH_RESET && init_hi && cnt == CW'(INIT_TMO - 1)) begin
            tmo_q <= 1'b1;
        end else if ((st == PH_SHIFT || st == PH_TRAIL) && !init_hi) begin
            err_q <= 1'b1;
        end else if (st == PH_TRAIL && done_hi) begin
            ok_q <= 1'b1;
        end else if (st == PH_TRAIL && trail_rise && cnt == CW'(TRAIL_MAX - 1)) begin
            tmo_q <= 1'b1;
        end
    end

    AST_RELEASE_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_q) |-> (!$past(init_hi) || tmo_q))
        else $error("program line released before init answered"); // R2
    AST_START_PROGRAMS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_IDLE && start) |=> !prog_q)
        else $error("start did not drive program line"); // R1
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st != PH_IDLE && start && prog_q) |=> prog_q)
        else $error("start while busy disturbed program line"); // R1
    AST_SINGLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ok_q, tmo_q, err_q}))
        else $error("more than one result flag"); // R11
endmodule

// File: rtl/bitload_ctrl.sv
`timescale 1ns/1ps
// Slave-serial bitstream loader top: synchronizes the target's init/done
// lines and joins the sequencer with the serializer.
// Assumes cfg_init_n and cfg_done are asynchronous levels from the target.
module bitload_ctrl
    import bitload_pkg::*;
#(
    parameter int HALF_CYC  = 3,
    parameter int WAIT_CYC  = 250,
    parameter int TRAIL_MAX = 64,
    parameter int INIT_TMO  = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              cfg_prog_n,
    output logic              cfg_cclk,
    output logic              cfg_din,
    input  logic              cfg_init_n,
    input  logic              cfg_done,
    output logic              busy,
    output logic              stat_ok,
    output logic              stat_timeout,
    output logic              stat_init_err
);
    logic [1:0] pins_s;
    logic       shift_en, trail_en, stream_end, trail_rise;

    bitload_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cfg_done, cfg_init_n}),
        .q     (pins_s)
    );

    bitload_seq #(.WAIT_CYC(WAIT_CYC), .TRAIL_MAX(TRAIL_MAX), .INIT_TMO(INIT_TMO)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .init_hi    (pins_s[0]),
        .done_hi    (pins_s[1]),
        .stream_end (stream_end),
        .trail_rise (trail_rise),
        .shift_en   (shift_en),
        .trail_en   (trail_en),
        .prog_n_o   (cfg_prog_n),
        .busy_o     (busy),
        .ok_o       (stat_ok),
        .tmo_o      (stat_timeout),
        .err_o      (stat_init_err)
    );

    bitload_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .trail_en   (trail_en),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .cclk_o     (cfg_cclk),
        .din_o      (cfg_din),
        .stream_end (stream_end),
        .trail_rise (trail_rise)
    );
endmodule

// File: tb/bitload_ctrl_test.sv
`timescale 1ns/1ps
module bitload_ctrl_test;
    localparam int HALF  = 2;
    localparam int WAIT  = 20;
    localparam int TRAIL = 16;
    localparam int ITMO  = 40;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, cfg_prog_n, cfg_cclk, cfg_din, busy, stat_ok, stat_timeout, stat_init_err;
    logic cfg_init_n, cfg_done;

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 1'b0;

    // target-model configuration, written by the stimulus only
    int run_id = 0, no_init = 0, err_bit = -1, done_after = -1, exp_bits = 0;
    byte unsigned tx_q[$];

    // target-model / monitor state, written by the monitor only
    int seen_run = 0, tphase = 0, rel_cnt = 0, nbits = 0, trail_cnt = 0;
    int hi_len = 0, lo_len = 0, prog_low_len = 0, prog_falls = 0;
    int init_fall_cyc = -1, prog_rise_cyc = -1, done_cyc = -1, err_cyc = -1;
    bit first_rise = 1'b0, init_drv = 1'b1, done_drv = 1'b0;
    bit prev_cclk = 1'b0, prev_din = 1'b1, prev_prog = 1'b1, prev_busy = 1'b0;
    bit cap[$];

    assign cfg_init_n = init_drv;
    assign cfg_done   = done_drv;

    bitload_ctrl #(.HALF_CYC(HALF), .WAIT_CYC(WAIT), .TRAIL_MAX(TRAIL), .INIT_TMO(ITMO)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .cfg_prog_n(cfg_prog_n), .cfg_cclk(cfg_cclk),
        .cfg_din(cfg_din), .cfg_init_n(cfg_init_n), .cfg_done(cfg_done), .busy(busy),
        .stat_ok(stat_ok), .stat_timeout(stat_timeout), .stat_init_err(stat_init_err));

    always #10 clk = ~clk;

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Cycle counter and watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    // Per-cycle reference checks and behavioural target device
    always @(negedge clk) begin
        if (run_id != seen_run) begin
            seen_run = run_id; tphase = 0; rel_cnt = 0; nbits = 0; trail_cnt = 0;
            prog_falls = 0; done_cyc = -1; err_cyc = -1; init_fall_cyc = -1;
            first_rise = 1'b0; init_drv = 1'b1; done_drv = 1'b0; cap.delete();
        end
        if (rst_n) begin
            chk(!(in_ready && !busy), "R6 ready while idle", int'(in_ready), 0);
            // serial clock edges
            if (cfg_cclk && !prev_cclk) begin
                if (busy && lo_len < HALF) chk(1'b0, "R5 low phase", lo_len, HALF);
                hi_len = 1;
                if (tphase == 2) begin
                    if (nbits < exp_bits) begin
                        cap.push_back(cfg_din);
                        nbits++;
                        if (first_rise) begin
                            chk(cyc - prog_rise_cyc >= WAIT + HALF, "R3 settle gap",
                                cyc - prog_rise_cyc, WAIT + HALF);
                            first_rise = 1'b0;
                        end
                        if (err_bit == nbits) begin init_drv = 1'b0; err_cyc = cyc; end
                    end else begin
                        trail_cnt++;
                        chk(cfg_din == 1'b1, "R7 trailing data high", int'(cfg_din), 1);
                        if (done_after == trail_cnt) begin done_drv = 1'b1; done_cyc = cyc; end
                    end
                end
            end else if (!cfg_cclk && prev_cclk) begin
                if (busy) chk(hi_len == HALF, "R5 high phase", hi_len, HALF);
                lo_len = 1;
            end else if (cfg_cclk) begin
                hi_len++;
                chk(cfg_din == prev_din, "R4 data stable while clock high", int'(cfg_din), int'(prev_din));
            end else begin
                lo_len++;
            end
            // program line
            if (!cfg_prog_n && prev_prog) begin
                prog_falls++; prog_low_len = 1;
            end else if (!cfg_prog_n) begin
                prog_low_len++;
            end else if (cfg_prog_n && !prev_prog) begin
                prog_rise_cyc = cyc; first_rise = 1'b1;
                if (no_init == 0) chk(cyc - init_fall_cyc == 3, "R2 release latency", cyc - init_fall_cyc, 3);
                else              chk(prog_low_len == ITMO, "R10 program low window", prog_low_len, ITMO);
            end
            // end of run latencies
            if (!busy && prev_busy) begin
                if (done_cyc >= 0) chk(cyc - done_cyc == 3 && stat_ok, "R7 done latency", cyc - done_cyc, 3);
                if (err_cyc >= 0)  chk(cyc - err_cyc == 3 && stat_init_err, "R8 error latency", cyc - err_cyc, 3);
            end
            // target reaction to the program line
            if (!cfg_prog_n) begin
                tphase = 1; rel_cnt = 0; done_drv = 1'b0;
                if (no_init == 0 && prog_low_len >= 2 && init_drv) begin
                    init_drv = 1'b0; init_fall_cyc = cyc;
                end
            end else if (tphase == 1) begin
                rel_cnt++;
                if (rel_cnt >= 4) begin init_drv = 1'b1; tphase = 2; end
            end
        end
        prev_cclk = cfg_cclk; prev_din = cfg_din; prev_prog = cfg_prog_n; prev_busy = busy;
    end

    // Feed the byte stream; stops if the load ends early
    task automatic feed(input int gap);
        for (int i = 0; i < tx_q.size(); i++) begin
            if (!busy) break;
            in_valid = 1'b1; in_data = tx_q[i]; in_last = (i == tx_q.size() - 1);
            while (!in_ready && busy) @(negedge clk);
            if (!busy) break;
            @(negedge clk);
            in_valid = 1'b0;
            repeat (gap) @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic run(input int gap, input bit mid_start);
        run_id++;
        @(negedge clk); @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cfg_prog_n == 1'b0, "R1 program low after start", int'(cfg_prog_n), 0);
        chk(busy && !stat_ok && !stat_timeout && !stat_init_err, "R1 busy and flags cleared",
            int'({busy, stat_ok, stat_timeout, stat_init_err}), 8);
        fork
            feed(gap);
            if (mid_start) begin
                repeat (40) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_bytes(input string req);
        for (int j = 0; j < tx_q.size(); j++) begin
            int v = 0;
            for (int b = 0; b < 8; b++) v = (v << 1) | ((8*j + b < cap.size()) ? int'(cap[8*j + b]) : 0);
            chk(v == int'(tx_q[j]), req, v, int'(tx_q[j]));
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(cfg_prog_n && !cfg_cclk && cfg_din, "R11 reset line levels",
            int'({cfg_prog_n, cfg_cclk, cfg_din}), 5);
        chk(!busy && !in_ready && !stat_ok && !stat_timeout && !stat_init_err, "R11 reset status",
            int'({busy, in_ready, stat_ok, stat_timeout, stat_init_err}), 0);

        // T1: back-to-back bytes, done after 5 trailing clocks (R4 R6 R7)
        tx_q = '{8'hA5, 8'h3C, 8'h01}; exp_bits = 24; no_init = 0; err_bit = -1; done_after = 5;
        run(0, 1'b0);
        check_bytes("R4 MSB-first byte");
        chk(stat_ok && !stat_timeout && !stat_init_err, "R7 success flag",
            int'({stat_ok, stat_timeout, stat_init_err}), 4);
        chk(trail_cnt == 5, "R7 trailing clocks before done", trail_cnt, 5);
        chk(!cfg_cclk && cfg_din, "R7 lines parked after success", int'({cfg_cclk, cfg_din}), 1);

        // T2: gapped stream, start pulse while busy, done after 1 (R1 R6)
        tx_q = '{8'hFF, 8'h00, 8'h80, 8'h7E}; exp_bits = 32; done_after = 1;
        run(3, 1'b1);
        check_bytes("R6 gapped stream byte");
        chk(prog_falls == 1, "R1 start while busy ignored", prog_falls, 1);
        chk(stat_ok, "R6 gapped stream success", int'(stat_ok), 1);

        // T3: done never rises (R9)
        tx_q = '{8'h5A, 8'hC3}; exp_bits = 16; done_after = -1;
        run(0, 1'b0);
        check_bytes("R9 bytes before timeout");
        chk(stat_timeout && !stat_ok && !stat_init_err, "R9 trailing timeout flag",
            int'({stat_ok, stat_timeout, stat_init_err}), 2);
        chk(trail_cnt == TRAIL, "R9 trailing clock count", trail_cnt, TRAIL);

        // T4: init drops on bit 5 (R8)
        tx_q = '{8'h96, 8'hF0}; exp_bits = 16; err_bit = 5;
        run(0, 1'b0);
        chk(stat_init_err && !stat_ok && !stat_timeout, "R8 error flag",
            int'({stat_ok, stat_timeout, stat_init_err}), 1);
        chk(nbits == 5, "R8 no clock after error", nbits, 5);
        chk(cap.size() == 5 && cap[0] == 1 && cap[1] == 0 && cap[2] == 0 && cap[3] == 1 && cap[4] == 0,
            "R8 bits before error", cap.size(), 5);
        chk(!cfg_cclk, "R8 clock parked low", int'(cfg_cclk), 0);

        // T5: init never answers (R10, flags cleared per R1)
        tx_q = '{8'h11}; exp_bits = 8; err_bit = -1; no_init = 1;
        run(0, 1'b0);
        chk(stat_timeout && !stat_init_err && !stat_ok, "R10 init timeout flag",
            int'({stat_ok, stat_timeout, stat_init_err}), 2);
        chk(nbits == 0 && cfg_prog_n, "R10 nothing clocked, line released", nbits, 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule